// File: doc/BRIEF.md
# Packed BCD Byte Adder with Condition Flags

This unit performs the arithmetic step of a processor's decimal-add instruction. It takes two 32-bit operands in which only the low byte holds two packed binary-coded-decimal digits, adds those bytes together with an incoming extend bit, and writes back the destination word with only its low byte replaced. It also updates the carry, extend and zero flags. The negative and overflow flags pass through unchanged.

A pulse on `in_valid` captures the inputs. One clock later `out_valid` rises and the registered result and flags appear. When `in_valid` is low the outputs hold their last value. Multi-byte decimal numbers are added one byte at a time. Each byte is issued with `x_i` taken from the previous `x_o` and with `flags_i` taken from the previous `flags_o`. Because the zero flag can only be cleared, the whole chain reports zero only when every result byte is zero. Digits above 9 are not trapped; they simply follow the arithmetic below.

Top module: `bcd_byte_adder`

## Requirements
- R1: With lo = src[3:0] + dst[3:0] + x_i and raw = (src[7:4]<<4) + (dst[7:4]<<4) + lo, the intermediate value is raw + 6 when lo > 9 and raw otherwise.
- R2: When bits 9:4 of that intermediate value exceed 9, 0x60 is added and the carry flag (flags_o bit 0) is set. Otherwise carry is cleared. Bits 7:0 of the final value form dst_o[7:0].
- R3: x_o always equals the new carry flag.
- R4: The zero flag (flags bit 2) is cleared when dst_o[7:0] is nonzero. Otherwise it keeps the value of flags_i bit 2.
- R5: The negative (bit 3) and overflow (bit 1) flags are copied from flags_i unchanged.
- R6: dst_o[DATA_W-1:8] equals dst_i[DATA_W-1:8] of the captured transaction.
- R7: A transaction presented with in_valid high produces out_valid high and its result exactly one clock later. out_valid is low in a cycle that follows one without in_valid.
- R8: While in_valid is low, dst_o, flags_o and x_o hold their values whatever the other inputs do.
- R9: A synchronous active-high reset clears out_valid, dst_o, flags_o and x_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the inputs |
| src_i | input | DATA_W | Source operand, low byte used |
| dst_i | input | DATA_W | Destination operand |
| x_i | input | 1 | Incoming extend bit |
| flags_i | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| dst_o | output | DATA_W | Destination with new low byte |
| flags_o | output | 4 | Updated flags {N,Z,V,C} |
| x_o | output | 1 | Updated extend bit |

## Verification
On every cycle the assertions check the fixed latency of the valid strobe, the equality of extend and carry, the stickiness of zero, the pass-through of the negative flag, the overflow flag and the upper word, and the holding of outputs between strobes. The decimal arithmetic itself, including every digit pair, both extend values and the handling of invalid digits, can only be confirmed by the bench. It sweeps all byte and extend combinations against its own model. Chained multi-byte additions, where extend and zero must carry across bytes, also belong to the bench scenarios.

// File: rtl/bcd_byte_adder.sv
module bcd_byte_adder #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              x_i,
  input  logic [3:0]        flags_i,
  output logic              out_valid,
  output logic [DATA_W-1:0] dst_o,
  output logic [3:0]        flags_o,
  output logic              x_o
);
  localparam int SUM_W = 10;
  localparam int F_N = 3, F_Z = 2, F_V = 1, F_C = 0;

  logic [4:0]       lo_sum;
  logic [SUM_W-1:0] raw_sum, low_fix, dec_sum;
  logic             dec_carry, byte_nz;

  assign lo_sum    = {1'b0, src_i[3:0]} + {1'b0, dst_i[3:0]} + {4'b0, x_i};
  assign raw_sum   = {2'b0, src_i[7:4], 4'b0} + {2'b0, dst_i[7:4], 4'b0} + {5'b0, lo_sum};
  assign low_fix   = (lo_sum > 5'd9) ? raw_sum + 10'h006 : raw_sum;
  assign dec_carry = low_fix[9:4] > 6'd9;
  assign dec_sum   = dec_carry ? low_fix + 10'h060 : low_fix;
  assign byte_nz   = dec_sum[7:0] != 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst_o     <= '0;
      flags_o   <= '0;
      x_o       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_o        <= {dst_i[DATA_W-1:8], dec_sum[7:0]};
        flags_o[F_N] <= flags_i[F_N];
        flags_o[F_Z] <= flags_i[F_Z] & ~byte_nz;
        flags_o[F_V] <= flags_i[F_V];
        flags_o[F_C] <= dec_carry;
        x_o          <= dec_carry;
      end
    end
  end
endmodule

// File: rtl/bcd_byte_adder_chk.sv
module bcd_byte_adder_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] dst_i,
  input logic [3:0]        flags_i,
  input logic              out_valid,
  input logic [DATA_W-1:0] dst_o,
  input logic [3:0]        flags_o,
  input logic              x_o
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R7
  AST_X_IS_C: assert property (@(posedge clk) disable iff (rst) out_valid |-> (x_o == flags_o[0])); // R3
  AST_Z_STICKY: assert property (@(posedge clk) disable iff (rst) (in_valid && !flags_i[2]) |=> !flags_o[2]); // R4
  AST_Z_NONZERO: assert property (@(posedge clk) disable iff (rst) (out_valid && dst_o[7:0] != 8'h00) |-> !flags_o[2]); // R4
  AST_NV_PASS: assert property (@(posedge clk) disable iff (rst) in_valid |=> (flags_o[3] == $past(flags_i[3]) && flags_o[1] == $past(flags_i[1]))); // R5
  AST_UPPER_PASS: assert property (@(posedge clk) disable iff (rst) in_valid |=> (dst_o[DATA_W-1:8] == $past(dst_i[DATA_W-1:8]))); // R6
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst) (!in_valid && !$past(rst)) |=> ($stable(dst_o) && $stable(flags_o) && $stable(x_o))); // R8
endmodule

bind bcd_byte_adder bcd_byte_adder_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .dst_i(dst_i), .flags_i(flags_i),
  .out_valid(out_valid), .dst_o(dst_o), .flags_o(flags_o), .x_o(x_o)
);

// File: tb/bcd_byte_adder_tb_top.sv
`timescale 1ns/1ps
module bcd_byte_adder_tb_top;
  localparam int DATA_W = 32;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst, in_valid, x_i, out_valid, x_o;
  logic [DATA_W-1:0] src_i, dst_i, dst_o;
  logic [3:0] flags_i, flags_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_byte_adder #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_i(src_i), .dst_i(dst_i),
    .x_i(x_i), .flags_i(flags_i), .out_valid(out_valid), .dst_o(dst_o),
    .flags_o(flags_o), .x_o(x_o)
  );

  // returns {carry, byte}
  function automatic logic [8:0] bcd_model(input logic [7:0] s, input logic [7:0] d, input logic x);
    int lo, r;
    lo = (s & 15) + (d & 15) + x;
    r  = (s & 8'hF0) + (d & 8'hF0) + lo;
    if (lo > 9) r += 6;
    if ((r & 10'h3F0) > 10'h090) return {1'b1, 8'(r + 10'h060)};
    return {1'b0, 8'(r)};
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DATA_W-1:0] e_dst;
  logic [3:0] e_flags;
  logic e_x;

  task automatic present(input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] d, input logic x, input logic [3:0] f);
    logic [8:0] m;
    src_i = s; dst_i = d; x_i = x; flags_i = f; in_valid = 1'b1;
    m = bcd_model(s[7:0], d[7:0], x);
    e_dst = {d[DATA_W-1:8], m[7:0]};
    e_x = m[8];
    e_flags = {f[3], f[2] & (m[7:0] == 8'h00), f[1], m[8]};
  endtask

  task automatic compare_all();
    chk("R7 out_valid", DATA_W'(out_valid), 1);
    chk("R1/R2 low byte", DATA_W'(dst_o[7:0]), DATA_W'(e_dst[7:0]));
    chk("R2 carry", DATA_W'(flags_o[0]), DATA_W'(e_flags[0]));
    chk("R3 extend", DATA_W'(x_o), DATA_W'(e_x));
    chk("R4 zero", DATA_W'(flags_o[2]), DATA_W'(e_flags[2]));
    chk("R5 N/V", DATA_W'({flags_o[3], flags_o[1]}), DATA_W'({e_flags[3], e_flags[1]}));
    chk("R6 upper", dst_o >> 8, e_dst >> 8);
  endtask

  task automatic single(input logic [DATA_W-1:0] s, input logic [DATA_W-1:0] d, input logic x, input logic [3:0] f);
    @(negedge clk);
    present(s, d, x, f);
    @(negedge clk);
    in_valid = 1'b0;
    compare_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; in_valid = 1'b0; src_i = '0; dst_i = '0; x_i = 1'b0; flags_i = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 out_valid", DATA_W'(out_valid), 0);
    chk("R9 dst_o", dst_o, 0);
    chk("R9 flags_o", DATA_W'({flags_o, x_o}), 0);
    rst = 1'b0;

    // directed corner cases
    single(32'h0000_0099, 32'hABCD_EF01, 1'b0, 4'b0100); // R2 99+01 -> 00 carry, R4 Z kept
    single(32'h0000_0045, 32'h1200_0054, 1'b1, 4'b1111); // R1 45+54+1 = 00 carry
    single(32'h0000_0009, 32'h0000_0000, 1'b1, 4'b0100); // R1 low adjust -> 10
    single(32'h0000_0000, 32'h0000_0000, 1'b0, 4'b0100); // R4 zero stays set
    single(32'h0000_0000, 32'h0000_0000, 1'b0, 4'b0000); // R4 zero stays clear
    single(32'h0000_00FF, 32'h0000_00FF, 1'b1, 4'b1010); // R1/R2 invalid digits

    // R8 hold while idle with changing inputs
    begin
      logic [DATA_W-1:0] hd; logic [3:0] hf; logic hx;
      hd = dst_o; hf = flags_o; hx = x_o;
      for (int i = 0; i < 4; i++) begin
        src_i = $urandom; dst_i = $urandom; x_i = ~x_i; flags_i = ~flags_i;
        @(negedge clk);
        chk("R8 hold dst", dst_o, hd);
        chk("R8 hold flags", DATA_W'({flags_o, x_o}), DATA_W'({hf, hx}));
        chk("R7 idle valid", DATA_W'(out_valid), 0);
      end
    end

    // chained three-byte adds: 999999 + 000001 = 000000 with carry out, zero kept
    begin
      logic [23:0] a [2];
      logic [23:0] b [2];
      logic [23:0] sum_exp [2];
      logic cx_exp [2];
      a[0] = 24'h999999; b[0] = 24'h000001; sum_exp[0] = 24'h000000; cx_exp[0] = 1'b1;
      a[1] = 24'h123456; b[1] = 24'h876544; sum_exp[1] = 24'h000000; cx_exp[1] = 1'b1;
      for (int c = 0; c < 2; c++) begin
        logic xc; logic [3:0] fc; logic [23:0] got;
        xc = 1'b0; fc = 4'b0100; got = '0;
        for (int k = 0; k < 3; k++) begin
          single(DATA_W'(a[c] >> (8 * k)) & 32'hFF, DATA_W'(b[c] >> (8 * k)) & 32'hFF, xc, fc);
          got[8*k +: 8] = dst_o[7:0];
          xc = x_o; fc = flags_o;
        end
        chk("R3 chain sum", DATA_W'(got), DATA_W'(sum_exp[c]));
        chk("R3 chain extend", DATA_W'(xc), DATA_W'(cx_exp[c]));
        chk("R4 chain zero", DATA_W'(fc[2]), 1);
      end
      begin
        logic xc; logic [3:0] fc;
        xc = 1'b0; fc = 4'b0100;
        single(32'h00, 32'h00, xc, fc); xc = x_o; fc = flags_o;
        single(32'h01, 32'h00, xc, fc); xc = x_o; fc = flags_o;
        single(32'h00, 32'h00, xc, fc); fc = flags_o;
        chk("R4 chain nonzero middle", DATA_W'(fc[2]), 0);
      end
    end

    // exhaustive back-to-back sweep with random upper bits and flags
    @(negedge clk);
    for (int x = 0; x < 2; x++) begin
      for (int s = 0; s < 256; s++) begin
        for (int d = 0; d < 256; d++) begin
          logic [31:0] rs, rd; logic [3:0] rf;
          rs = $urandom; rd = $urandom; rf = 4'($urandom);
          present({rs[31:8], 8'(s)}, {rd[31:8], 8'(d)}, 1'(x), rf);
          @(negedge clk);
          compare_all();
        end
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 valid drops", DATA_W'(out_valid), 0);

    // R9 reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 reset clears", DATA_W'({out_valid, flags_o, x_o}), 0);
    chk("R9 reset dst", dst_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule